// File: doc/BRIEF.md
# Bidirectional BAR Address Translator

This block rewrites memory addresses between a memory-mapped AXI fabric and a PCIe transaction layer. Each direction has its own map. Outbound, an AXI read or write address is matched against a set of fixed AXI windows. Each window has a power-of-two aperture and an aperture-aligned low address. When a window matches, the address bits above the aperture are replaced by that window's PCIe translation base, and the bits below it pass through unchanged. When no window matches, a decode error is flagged and no translated request is produced.

Inbound, a PCIe request arrives with a BAR-hit index and is converted to an AXI master address. The offset within the BAR is kept, and the bits above the BAR aperture are taken from that BAR's fixed AXI translation base. An index that names no BAR is rejected.

An AXI-Lite slave gives software read and write access to the outbound translation bases, so the outbound map can be moved while the block is running. A written base is forced to the aperture alignment of its window. A new base applies only to requests decoded after its write response has been accepted. The inbound map cannot be changed by software.

Top module: `bar_xlate_unit`

## Requirements
- R1: After reset, no output flag is raised: no outbound result, no decode error, no inbound result, no reject, and no AXI-Lite response pending. The translation registers read back their aligned reset values: window 0 is 0x0000_0000_8000_0000 and window 1 is 0x0000_0002_0000_0000.
- R2: An outbound request in window 0 (0x7000_0000 to 0x7FFF_FFFF) yields its PCIe address on `ob_out_addr` with `ob_out_valid` high one clock after it is presented. The PCIe address is the window base with the low 28 bits copied from the request, so 0x7001_0000 with base 0x8000_0000 gives 0x8001_0000.
- R3: Both ends of each window hit. An address just below a window's low address, or just above its high address, or matching no window, raises `ob_decerr` for one clock with `ob_out_valid` low. The two flags are never high together.
- R4: Window 1 (0x4000_0000 to 0x400F_FFFF, 1 MB aperture) uses its own translation base, independent of window 0. The low 20 bits come from the request.
- R5: For a valid BAR index, an inbound request produces `ib_out_valid` one clock later. The AXI address is the BAR's AXI base above the aperture and the request's offset inside the aperture below it. BAR 0 has a 64 KB aperture and base 0, so BAR address + 0x1000 gives 0x1000. BAR 1 has a 4 KB aperture and base 0x0003_0000.
- R6: An inbound request whose BAR index is 2 or greater raises `ib_reject` one clock later, with `ib_out_valid` low.
- R7: AXI-Lite register map, 32-bit words:
  - 0x208 is the lower word of window 0's base, and 0x20C is its upper word.
  - 0x210 is the lower word of window 1's base, and 0x214 is its upper word.
  - Every other offset, including offsets that are not word-aligned, reads 0 and ignores writes.
  - Every response is OKAY (00).
  - A response is held until it is accepted.
- R8: When a value is written to a lower word, its bits below the window aperture are stored as 0. Both the read-back value and later translations show the aligned value. Upper-word writes are stored as given.
- R9: A translation base that has been written does not affect any request decoded before the write response handshake completes. Requests presented after that handshake use the new base.
- R10: Changing the outbound bases has no effect on inbound translation.
- R11: A write updates only the byte lanes whose `csr_wstrb` bit is set, with bit n selecting data bits 8n+7:8n. Alignment masking is applied after the bytes are merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ob_req_valid | input | 1 | Outbound AXI address present |
| ob_req_addr | input | 32 | Outbound AXI address |
| ob_out_valid | output | 1 | Translated PCIe address valid |
| ob_out_addr | output | 64 | Translated PCIe address |
| ob_decerr | output | 1 | Outbound address hit no window |
| ib_req_valid | input | 1 | Inbound PCIe request present |
| ib_req_bar | input | 2 | BAR-hit index of the inbound request |
| ib_req_addr | input | 64 | Inbound PCIe address |
| ib_out_valid | output | 1 | Translated AXI master address valid |
| ib_out_addr | output | 32 | Translated AXI master address |
| ib_reject | output | 1 | Inbound BAR index invalid |
| csr_awaddr | input | 12 | AXI-Lite write address |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address accepted |
| csr_wdata | input | 32 | Write data |
| csr_wstrb | input | 4 | Write byte strobes |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data accepted |
| csr_bresp | output | 2 | Write response code |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response accepted |
| csr_araddr | input | 12 | Read address |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address accepted |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response code |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data accepted |

## Verification
The bench probes each window at its low address, its high address, and one step outside on both sides. A decoder with an off-by-one compare or a wrong aperture would translate the out-of-range address or miss a valid end.

It writes unaligned values and partial byte strobes to the lower words. A design that skipped the alignment mask, or merged strobes wrongly, would show stray low bits both on read-back and in translated addresses.

It holds the write response open while it sends outbound requests. An implementation that committed the new base at the address handshake would translate those requests with the new base too early. It also sends inbound requests after the outbound reprogramming and with out-of-range BAR indices, to catch maps that share state or accept a BAR that does not exist.

// File: rtl/bxl_pkg.sv
package bxl_pkg;

    // PCIe side addresses are always 64 bits: the register layout splits them in two words
    localparam int unsigned PCIE_AW = 64;
    localparam int unsigned CSR_AW  = 12;
    // First outbound base register; window n sits 8*n bytes above it
    localparam logic [CSR_AW-1:0] OB_XLATE_OFS = 12'h208;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } axil_resp_e;

    // Bits that lie inside an aperture of 2**lg bytes
    function automatic logic [63:0] aper_mask64(input logic [7:0] lg);
        return (64'd1 << lg) - 64'd1;
    endfunction

endpackage

// File: rtl/bxl_ob_decode.sv
module bxl_ob_decode
    import bxl_pkg::*;
#(
    parameter int unsigned                        NUM_OB  = 2,
    parameter int unsigned                        AXI_AW  = 32,
    parameter logic [NUM_OB-1:0][AXI_AW-1:0]      OB_LOW  = '0,
    parameter logic [NUM_OB-1:0][7:0]             OB_APER = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [AXI_AW-1:0]                 req_addr,
    input  logic [NUM_OB-1:0][PCIE_AW-1:0]    xlate_base,
    output logic                              out_valid,
    output logic [PCIE_AW-1:0]                out_addr,
    output logic                              decerr
);

    typedef struct packed {
        logic               vld;
        logic               err;
        logic [PCIE_AW-1:0] addr;
    } ob_state_t;

    ob_state_t s_d, s_q;

    logic [NUM_OB-1:0]              win_hit;
    logic [NUM_OB-1:0][PCIE_AW-1:0] win_xl;

    // One comparator and one bit-splice per window
    for (genvar gi = 0; gi < NUM_OB; gi++) begin : g_win
        localparam logic [AXI_AW-1:0]  AMASK = AXI_AW'(aper_mask64(OB_APER[gi]));
        localparam logic [PCIE_AW-1:0] PMASK = aper_mask64(OB_APER[gi]);
        assign win_hit[gi] = ((req_addr ^ OB_LOW[gi]) & ~AMASK) == '0;
        assign win_xl[gi]  = (xlate_base[gi] & ~PMASK) | (PCIE_AW'(req_addr) & PMASK);
    end

    always_comb begin
        s_d = '0;
        if (req_valid) begin
            s_d.err = 1'b1;
            // Walk downward so the lowest-numbered window wins an overlap
            for (int i = NUM_OB - 1; i >= 0; i--) begin
                if (win_hit[i]) begin
                    s_d.vld  = 1'b1;
                    s_d.err  = 1'b0;
                    s_d.addr = win_xl[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign decerr    = s_q.err;
    assign out_addr  = s_q.addr;

endmodule

// File: rtl/bxl_ib_xlate.sv
module bxl_ib_xlate
    import bxl_pkg::*;
#(
    parameter int unsigned                     NUM_IB   = 2,
    parameter int unsigned                     IDX_W    = 2,
    parameter int unsigned                     AXI_AW   = 32,
    parameter logic [NUM_IB-1:0][7:0]          IB_APER  = '0,
    parameter logic [NUM_IB-1:0][AXI_AW-1:0]   IB_XLATE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [IDX_W-1:0]     req_bar,
    input  logic [PCIE_AW-1:0]   req_addr,
    output logic                 out_valid,
    output logic [AXI_AW-1:0]    out_addr,
    output logic                 reject
);

    typedef struct packed {
        logic              vld;
        logic              rej;
        logic [AXI_AW-1:0] addr;
    } ib_state_t;

    ib_state_t s_d, s_q;

    logic [NUM_IB-1:0][AXI_AW-1:0] bar_xl;
    logic                          ib_addr_unused;

    // The BAR base is aperture-aligned, so the offset is just the low bits
    assign ib_addr_unused = ^req_addr[PCIE_AW-1:AXI_AW];

    for (genvar gi = 0; gi < NUM_IB; gi++) begin : g_bar
        localparam logic [AXI_AW-1:0] AMASK = AXI_AW'(aper_mask64(IB_APER[gi]));
        assign bar_xl[gi] = (IB_XLATE[gi] & ~AMASK) | (req_addr[AXI_AW-1:0] & AMASK);
    end

    always_comb begin
        s_d = '0;
        if (req_valid) begin
            if (32'(req_bar) < NUM_IB) begin
                s_d.vld = 1'b1;
                for (int i = 0; i < NUM_IB; i++) begin
                    if (32'(req_bar) == i) s_d.addr = bar_xl[i];
                end
            end else begin
                s_d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign reject    = s_q.rej;
    assign out_addr  = s_q.addr;

endmodule

// File: rtl/bxl_csr.sv
module bxl_csr
    import bxl_pkg::*;
#(
    parameter int unsigned                     NUM_OB       = 2,
    parameter logic [NUM_OB-1:0][7:0]          OB_APER      = '0,
    parameter logic [NUM_OB-1:0][PCIE_AW-1:0]  OB_XLATE_RST = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CSR_AW-1:0]               awaddr,
    input  logic                            awvalid,
    output logic                            awready,
    input  logic [31:0]                     wdata,
    input  logic [3:0]                      wstrb,
    input  logic                            wvalid,
    output logic                            wready,
    output logic [1:0]                      bresp,
    output logic                            bvalid,
    input  logic                            bready,
    input  logic [CSR_AW-1:0]               araddr,
    input  logic                            arvalid,
    output logic                            arready,
    output logic [31:0]                     rdata,
    output logic [1:0]                      rresp,
    output logic                            rvalid,
    input  logic                            rready,
    output logic [NUM_OB-1:0][PCIE_AW-1:0]  xlate_base
);

    localparam int unsigned       WIN_W = (NUM_OB > 1) ? $clog2(NUM_OB) : 1;
    localparam logic [CSR_AW-1:0] SPAN  = CSR_AW'(8 * NUM_OB);

    typedef struct packed {
        logic                            bvld;
        logic                            rvld;
        logic [31:0]                     rdat;
        logic                            pend;
        logic [WIN_W-1:0]                pwin;
        logic                            phi;
        logic [31:0]                     pdata;
        logic [NUM_OB-1:0][PCIE_AW-1:0]  base;
    } csr_state_t;

    function automatic csr_state_t reset_state();
        csr_state_t r;
        r = '0;
        for (int i = 0; i < NUM_OB; i++) begin
            r.base[i] = OB_XLATE_RST[i] & ~aper_mask64(OB_APER[i]);
        end
        return r;
    endfunction

    function automatic logic in_map(input logic [CSR_AW-1:0] a);
        logic [CSR_AW-1:0] off;
        off = a - OB_XLATE_OFS;
        return (a >= OB_XLATE_OFS) && (off < SPAN) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [WIN_W-1:0] win_of(input logic [CSR_AW-1:0] a);
        logic [CSR_AW-1:0] off;
        off = a - OB_XLATE_OFS;
        return WIN_W'(off >> 3);
    endfunction

    function automatic logic hi_of(input logic [CSR_AW-1:0] a);
        logic [CSR_AW-1:0] off;
        off = a - OB_XLATE_OFS;
        return off[2];
    endfunction

    csr_state_t s_d, s_q;

    logic             aw_hs;
    logic [WIN_W-1:0] w_win;
    logic             w_hi;
    logic [31:0]      w_cur;
    logic [31:0]      w_mrg;
    logic [WIN_W-1:0] r_win;
    logic             r_hi;

    assign aw_hs = awvalid && wvalid && !s_q.bvld;
    assign w_win = win_of(awaddr);
    assign w_hi  = hi_of(awaddr);
    assign r_win = win_of(araddr);
    assign r_hi  = hi_of(araddr);

    always_comb begin
        s_d   = s_q;
        w_cur = w_hi ? s_q.base[w_win][63:32] : s_q.base[w_win][31:0];
        w_mrg = w_cur;
        for (int b = 0; b < 4; b++) begin
            if (wstrb[b]) w_mrg[8*b +: 8] = wdata[8*b +: 8];
        end
        if (!w_hi) w_mrg = w_mrg & ~32'(aper_mask64(OB_APER[w_win]));

        // Response accepted: the staged value goes live now
        if (s_q.bvld && bready) begin
            s_d.bvld = 1'b0;
            s_d.pend = 1'b0;
            if (s_q.pend) begin
                if (s_q.phi) s_d.base[s_q.pwin][63:32] = s_q.pdata;
                else         s_d.base[s_q.pwin][31:0]  = s_q.pdata;
            end
        end

        // Address and data are taken together and staged until the response is taken
        if (aw_hs) begin
            s_d.bvld  = 1'b1;
            s_d.pend  = in_map(awaddr);
            s_d.pwin  = w_win;
            s_d.phi   = w_hi;
            s_d.pdata = w_mrg;
        end

        if (s_q.rvld && rready) s_d.rvld = 1'b0;
        if (arvalid && !s_q.rvld) begin
            s_d.rvld = 1'b1;
            if (in_map(araddr)) begin
                s_d.rdat = r_hi ? s_q.base[r_win][63:32] : s_q.base[r_win][31:0];
            end else begin
                s_d.rdat = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign awready    = aw_hs;
    assign wready     = aw_hs;
    assign bvalid     = s_q.bvld;
    assign bresp      = RESP_OKAY;
    assign arready    = !s_q.rvld;
    assign rvalid     = s_q.rvld;
    assign rdata      = s_q.rdat;
    assign rresp      = RESP_OKAY;
    assign xlate_base = s_q.base;

endmodule

// File: rtl/bar_xlate_unit.sv
module bar_xlate_unit
    import bxl_pkg::*;
#(
    parameter int unsigned                     NUM_OB       = 2,
    parameter int unsigned                     NUM_IB       = 2,
    parameter int unsigned                     AXI_AW       = 32,
    parameter logic [NUM_OB-1:0][AXI_AW-1:0]   OB_LOW       = {32'h4000_0000, 32'h7000_0000},
    parameter logic [NUM_OB-1:0][7:0]          OB_APER      = {8'd20, 8'd28},
    parameter logic [NUM_OB-1:0][63:0]         OB_XLATE_RST = {64'h0000_0002_0000_0000, 64'h0000_0000_8000_0000},
    parameter logic [NUM_IB-1:0][7:0]          IB_APER      = {8'd12, 8'd16},
    parameter logic [NUM_IB-1:0][AXI_AW-1:0]   IB_XLATE     = {32'h0003_0000, 32'h0000_0000},
    localparam int unsigned                    IB_IDX_W     = $clog2(NUM_IB) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ob_req_valid,
    input  logic [AXI_AW-1:0]     ob_req_addr,
    output logic                  ob_out_valid,
    output logic [63:0]           ob_out_addr,
    output logic                  ob_decerr,
    input  logic                  ib_req_valid,
    input  logic [IB_IDX_W-1:0]   ib_req_bar,
    input  logic [63:0]           ib_req_addr,
    output logic                  ib_out_valid,
    output logic [AXI_AW-1:0]     ib_out_addr,
    output logic                  ib_reject,
    input  logic [11:0]           csr_awaddr,
    input  logic                  csr_awvalid,
    output logic                  csr_awready,
    input  logic [31:0]           csr_wdata,
    input  logic [3:0]            csr_wstrb,
    input  logic                  csr_wvalid,
    output logic                  csr_wready,
    output logic [1:0]            csr_bresp,
    output logic                  csr_bvalid,
    input  logic                  csr_bready,
    input  logic [11:0]           csr_araddr,
    input  logic                  csr_arvalid,
    output logic                  csr_arready,
    output logic [31:0]           csr_rdata,
    output logic [1:0]            csr_rresp,
    output logic                  csr_rvalid,
    input  logic                  csr_rready
);

    logic [NUM_OB-1:0][PCIE_AW-1:0] ob_base;

    bxl_csr #(
        .NUM_OB       (NUM_OB),
        .OB_APER      (OB_APER),
        .OB_XLATE_RST (OB_XLATE_RST)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (csr_awaddr),
        .awvalid    (csr_awvalid),
        .awready    (csr_awready),
        .wdata      (csr_wdata),
        .wstrb      (csr_wstrb),
        .wvalid     (csr_wvalid),
        .wready     (csr_wready),
        .bresp      (csr_bresp),
        .bvalid     (csr_bvalid),
        .bready     (csr_bready),
        .araddr     (csr_araddr),
        .arvalid    (csr_arvalid),
        .arready    (csr_arready),
        .rdata      (csr_rdata),
        .rresp      (csr_rresp),
        .rvalid     (csr_rvalid),
        .rready     (csr_rready),
        .xlate_base (ob_base)
    );

    bxl_ob_decode #(
        .NUM_OB  (NUM_OB),
        .AXI_AW  (AXI_AW),
        .OB_LOW  (OB_LOW),
        .OB_APER (OB_APER)
    ) u_ob (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (ob_req_valid),
        .req_addr   (ob_req_addr),
        .xlate_base (ob_base),
        .out_valid  (ob_out_valid),
        .out_addr   (ob_out_addr),
        .decerr     (ob_decerr)
    );

    bxl_ib_xlate #(
        .NUM_IB   (NUM_IB),
        .IDX_W    (IB_IDX_W),
        .AXI_AW   (AXI_AW),
        .IB_APER  (IB_APER),
        .IB_XLATE (IB_XLATE)
    ) u_ib (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (ib_req_valid),
        .req_bar   (ib_req_bar),
        .req_addr  (ib_req_addr),
        .out_valid (ib_out_valid),
        .out_addr  (ib_out_addr),
        .reject    (ib_reject)
    );

endmodule

// File: rtl/bxl_checks.sv
module bxl_checks #(
    parameter int unsigned NUM_IB   = 2,
    parameter int unsigned IB_IDX_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ob_req_valid,
    input logic                ob_out_valid,
    input logic                ob_decerr,
    input logic                ib_req_valid,
    input logic [IB_IDX_W-1:0] ib_req_bar,
    input logic                ib_out_valid,
    input logic                ib_reject,
    input logic [1:0]          csr_bresp,
    input logic                csr_bvalid,
    input logic                csr_bready,
    input logic [31:0]         csr_rdata,
    input logic                csr_rvalid,
    input logic                csr_rready
);

    // R3
    ob_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ob_out_valid && ob_decerr));

    // R2
    ob_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_req_valid |=> (ob_out_valid || ob_decerr));

    // R2
    ob_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ob_req_valid |=> (!ob_out_valid && !ob_decerr));

    // R5
    ib_good_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req_valid && (32'(ib_req_bar) < NUM_IB)) |=> (ib_out_valid && !ib_reject));

    // R6
    ib_bad_bar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req_valid && (32'(ib_req_bar) >= NUM_IB)) |=> (ib_reject && !ib_out_valid));

    // R7
    b_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_bvalid && !csr_bready) |=> csr_bvalid);

    // R7
    r_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rvalid && !csr_rready) |=> (csr_rvalid && $stable(csr_rdata)));

    // R7
    b_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_bvalid |-> (csr_bresp == 2'b00));

endmodule

bind bar_xlate_unit bxl_checks #(
    .NUM_IB   (NUM_IB),
    .IB_IDX_W (IB_IDX_W)
) u_bxl_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ob_req_valid (ob_req_valid),
    .ob_out_valid (ob_out_valid),
    .ob_decerr    (ob_decerr),
    .ib_req_valid (ib_req_valid),
    .ib_req_bar   (ib_req_bar),
    .ib_out_valid (ib_out_valid),
    .ib_reject    (ib_reject),
    .csr_bresp    (csr_bresp),
    .csr_bvalid   (csr_bvalid),
    .csr_bready   (csr_bready),
    .csr_rdata    (csr_rdata),
    .csr_rvalid   (csr_rvalid),
    .csr_rready   (csr_rready)
);

// File: tb/bar_xlate_unit_test.sv
`timescale 1ns/1ps
module bar_xlate_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ob_req_valid = 1'b0;
    logic [31:0] ob_req_addr = '0;
    logic        ob_out_valid;
    logic [63:0] ob_out_addr;
    logic        ob_decerr;
    logic        ib_req_valid = 1'b0;
    logic [1:0]  ib_req_bar = '0;
    logic [63:0] ib_req_addr = '0;
    logic        ib_out_valid;
    logic [31:0] ib_out_addr;
    logic        ib_reject;
    logic [11:0] csr_awaddr = '0;
    logic        csr_awvalid = 1'b0;
    logic        csr_awready;
    logic [31:0] csr_wdata = '0;
    logic [3:0]  csr_wstrb = '0;
    logic        csr_wvalid = 1'b0;
    logic        csr_wready;
    logic [1:0]  csr_bresp;
    logic        csr_bvalid;
    logic        csr_bready = 1'b0;
    logic [11:0] csr_araddr = '0;
    logic        csr_arvalid = 1'b0;
    logic        csr_arready;
    logic [31:0] csr_rdata;
    logic [1:0]  csr_rresp;
    logic        csr_rvalid;
    logic        csr_rready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bar_xlate_unit uut (.*);

    typedef struct {
        string       tag;
        logic        err;
        logic [63:0] addr;
    } exp_t;

    exp_t ob_q[$];
    exp_t ib_q[$];

    // Bench copy of the outbound bases, updated only when a response completes
    logic [1:0][63:0] exp_base;
    logic             pend_ok;
    logic             pend_hi;
    int               pend_win;
    logic [31:0]      pend_val;

    function automatic exp_t ob_ref(input logic [31:0] a, input string tag);
        exp_t e;
        e.tag = tag; e.err = 1'b1; e.addr = '0;
        if (a[31:28] == 4'h7) begin
            e.err = 1'b0; e.addr = {exp_base[0][63:28], a[27:0]};
        end else if (a[31:20] == 12'h400) begin
            e.err = 1'b0; e.addr = {exp_base[1][63:20], a[19:0]};
        end
        return e;
    endfunction

    function automatic exp_t ib_ref(input logic [1:0] bar, input logic [63:0] a, input string tag);
        exp_t e;
        e.tag = tag; e.err = 1'b0; e.addr = '0;
        if (bar == 2'd0)      e.addr = {48'h0, a[15:0]};
        else if (bar == 2'd1) e.addr = {32'h0, 20'h00030, a[11:0]};
        else                  e.err = 1'b1;
        return e;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ob_send(input logic [31:0] a, input string tag);
        @(negedge clk);
        ob_req_valid = 1'b1;
        ob_req_addr  = a;
        ob_q.push_back(ob_ref(a, tag));
        @(negedge clk);
        ob_req_valid = 1'b0;
    endtask

    task automatic ib_send(input logic [1:0] bar, input logic [63:0] a, input string tag);
        @(negedge clk);
        ib_req_valid = 1'b1;
        ib_req_bar   = bar;
        ib_req_addr  = a;
        ib_q.push_back(ib_ref(bar, a, tag));
        @(negedge clk);
        ib_req_valid = 1'b0;
    endtask

    task automatic csr_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_araddr  = a;
        csr_arvalid = 1'b1;
        @(negedge clk);
        csr_arvalid = 1'b0;
        check({tag, " rvalid"}, {63'h0, csr_rvalid}, 64'h1);
        check({tag, " rdata"}, {32'h0, csr_rdata}, {32'h0, exp});
        check({tag, " rresp"}, {62'h0, csr_rresp}, 64'h0);
        csr_rready = 1'b1;
        @(negedge clk);
        csr_rready = 1'b0;
    endtask

    // Address and data phase; the response is left pending
    task automatic csr_write_req(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input string tag);
        logic [31:0] cur;
        @(negedge clk);
        csr_awaddr  = a;  csr_awvalid = 1'b1;
        csr_wdata   = d;  csr_wstrb   = s;  csr_wvalid = 1'b1;
        @(negedge clk);
        csr_awvalid = 1'b0;
        csr_wvalid  = 1'b0;
        check({tag, " bvalid"}, {63'h0, csr_bvalid}, 64'h1);
        check({tag, " bresp"}, {62'h0, csr_bresp}, 64'h0);
        pend_ok  = (a >= 12'h208) && (a < 12'h218) && (a[1:0] == 2'b00);
        pend_win = (a - 12'h208) >> 3;
        pend_hi  = a[2] ^ 1'b0;
        pend_hi  = ((a - 12'h208) >> 2) & 1;
        if (pend_ok) begin
            cur = pend_hi ? exp_base[pend_win][63:32] : exp_base[pend_win][31:0];
            for (int b = 0; b < 4; b++) if (s[b]) cur[8*b +: 8] = d[8*b +: 8];
            if (!pend_hi) cur = (pend_win == 0) ? (cur & 32'hF000_0000) : (cur & 32'hFFF0_0000);
            pend_val = cur;
        end
    endtask

    task automatic csr_write_done();
        @(negedge clk);
        csr_bready = 1'b1;
        @(negedge clk);
        csr_bready = 1'b0;
        if (pend_ok) begin
            if (pend_hi) exp_base[pend_win][63:32] = pend_val;
            else         exp_base[pend_win][31:0]  = pend_val;
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input string tag);
        csr_write_req(a, d, s, tag);
        csr_write_done();
    endtask

    // Scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && (ob_out_valid || ob_decerr)) begin
            checks++;
            if (ob_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected outbound result valid=%0b err=%0b, expected none", ob_out_valid, ob_decerr);
            end else begin
                exp_t e;
                e = ob_q.pop_front();
                if (ob_decerr !== e.err || ob_out_valid !== !e.err || (!e.err && ob_out_addr !== e.addr)) begin
                    errors++;
                    $display("FAIL %s: actual err=%0b addr=%h expected err=%0b addr=%h",
                             e.tag, ob_decerr, ob_out_addr, e.err, e.addr);
                end
            end
        end
        if (rst_n && (ib_out_valid || ib_reject)) begin
            checks++;
            if (ib_q.size() == 0) begin
                errors++;
                $display("FAIL R5: unexpected inbound result valid=%0b rej=%0b, expected none", ib_out_valid, ib_reject);
            end else begin
                exp_t e;
                e = ib_q.pop_front();
                if (ib_reject !== e.err || ib_out_valid !== !e.err || (!e.err && {32'h0, ib_out_addr} !== e.addr)) begin
                    errors++;
                    $display("FAIL %s: actual rej=%0b addr=%h expected rej=%0b addr=%h",
                             e.tag, ib_reject, ib_out_addr, e.err, e.addr[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_base[0] = 64'h0000_0000_8000_0000;
        exp_base[1] = 64'h0000_0002_0000_0000;
        pend_ok = 1'b0; pend_hi = 1'b0; pend_win = 0; pend_val = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ob_out_valid", {63'h0, ob_out_valid}, 64'h0);
        check("R1 ob_decerr",    {63'h0, ob_decerr},    64'h0);
        check("R1 ib_out_valid", {63'h0, ib_out_valid}, 64'h0);
        check("R1 ib_reject",    {63'h0, ib_reject},    64'h0);
        check("R1 bvalid",       {63'h0, csr_bvalid},   64'h0);
        check("R1 rvalid",       {63'h0, csr_rvalid},   64'h0);
        csr_read(12'h208, 32'h8000_0000, "R1 w0 lo");
        csr_read(12'h20C, 32'h0000_0000, "R1 w0 hi");
        csr_read(12'h210, 32'h0000_0000, "R1 w1 lo");
        csr_read(12'h214, 32'h0000_0002, "R1 w1 hi");

        // R2 window 0 translation
        ob_send(32'h7001_0000, "R2 example");
        ob_send(32'h7000_0000, "R2 low edge");
        ob_send(32'h7FFF_FFFF, "R2 high edge");

        // R3 misses just outside the windows
        ob_send(32'h8000_0000, "R3 w0 high+1");
        ob_send(32'h6FFF_FFFF, "R3 w0 low-1");
        ob_send(32'h4010_0000, "R3 w1 high+1");
        ob_send(32'h3FFF_FFFF, "R3 w1 low-1");
        ob_send(32'h0000_0000, "R3 zero");

        // R4 window 1
        ob_send(32'h4000_0000, "R4 low edge");
        ob_send(32'h400F_FFFF, "R4 high edge");
        ob_send(32'h4001_2345, "R4 mid");

        // R5 inbound, R6 bad index, overlapped with outbound traffic
        ib_send(2'd0, 64'h0000_00E0_0000_1000, "R5 bar0 +0x1000");
        ib_send(2'd0, 64'h0000_00E0_0000_FFFF, "R5 bar0 top");
        ib_send(2'd1, 64'hFEDC_B000_0000_0ABC, "R5 bar1");
        ib_send(2'd2, 64'h0000_00E0_0000_1000, "R6 bar2");
        ib_send(2'd3, 64'h0000_00E0_0000_1000, "R6 bar3");
        fork
            ob_send(32'h7123_4567, "R2 concurrent");
            ib_send(2'd1, 64'h0000_0001_0000_0123, "R5 concurrent");
        join

        // R7 map and reserved offsets
        csr_read(12'h200, 32'h0, "R7 below map");
        csr_read(12'h218, 32'h0, "R7 above map");
        csr_read(12'h20A, 32'h0, "R7 unaligned");
        csr_write(12'h300, 32'hFFFF_FFFF, 4'hF, "R7 reserved write");
        csr_read(12'h208, 32'h8000_0000, "R7 w0 lo after reserved write");
        csr_read(12'h214, 32'h0000_0002, "R7 w1 hi after reserved write");

        // R8 alignment of written values
        csr_write(12'h208, 32'h9123_4567, 4'hF, "R8 w0 lo");
        csr_read(12'h208, 32'h9000_0000, "R8 w0 lo readback");
        ob_send(32'h7001_0000, "R8 translate aligned");
        csr_write(12'h20C, 32'h0000_0001, 4'hF, "R8 w0 hi");
        csr_read(12'h20C, 32'h0000_0001, "R8 w0 hi readback");
        ob_send(32'h7001_0000, "R8 translate upper");

        // R9 new base waits for the response handshake
        csr_write_req(12'h208, 32'hA000_0000, 4'hF, "R9 w0 lo");
        ob_send(32'h7001_0000, "R9 during open response");
        ob_send(32'h7FFF_0000, "R9 during open response 2");
        check("R9 bvalid held", {63'h0, csr_bvalid}, 64'h1);
        csr_write_done();
        ob_send(32'h7001_0000, "R9 after response");

        // R11 byte strobes
        csr_write(12'h210, 32'hFFFF_FFFF, 4'b0100, "R11 w1 lo lane2");
        csr_read(12'h210, 32'h00F0_0000, "R11 readback");
        ob_send(32'h4000_0010, "R11 translate");

        // R10 inbound map untouched by outbound programming
        ib_send(2'd0, 64'h0000_00E0_0000_1000, "R10 bar0");
        ib_send(2'd1, 64'hFEDC_B000_0000_0ABC, "R10 bar1");

        repeat (4) @(negedge clk);
        check("R2 outbound results missing", 64'(ob_q.size()), 64'h0);
        check("R5 inbound results missing", 64'(ib_q.size()), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule